// File: doc/BRIEF.md
# Padded Message Bitslice Segmenter

This block sits at the front of a pseudo-dot-product hash over a 256-bit binary field. It takes a message one byte at a time, pads it, cuts the padded stream into segments and bit-transposes each segment into 256-bit field-element words. The hash arithmetic that uses those words lies outside the block.

A message ends with a byte carrying `in_last`. The block then appends one byte of value 0x01 and as many zero bytes as it needs to reach a multiple of 64·B bytes, where B (1 to 8) is fixed at elaboration. Each group of 64·B padded bytes is split into two segments of 32·B bytes: a primary segment (the first half) and a partner segment (the second half). The bits of a segment are numbered k = 8·(byte index) + (bit index within the byte). Bit k is bit k/B of row word k mod B, so segment bit k lands in row k mod B at column k/B. When B is 1 there is no transposition, and a 32-byte segment is one word, byte 0 in bits 7:0. Within a group the words are emitted in the order primary row 0, partner row 0, primary row 1, partner row 1, and so on.

A group is stored whole before any of its words leave the block. While a group is being padded or emitted, `in_ready` stays low, so backpressure at the output stalls the input. A beat with `in_empty` set carries no byte, and a beat with both `in_empty` and `in_last` ends a message of zero length.

Top module: `msg_bitslice_segmenter`

## Requirements
- R1: After the last message byte the padded stream holds one byte 0x01 followed by zero bytes, and its total length is the smallest multiple of 64·B bytes that leaves room for the 0x01 byte.
- R2: A message whose length is already a multiple of 64·B bytes gets one whole extra group, starting with 0x01 and filled with zeros.
- R3: An accepted beat with `in_empty`=1 and `in_last`=1 ends a message without adding a byte. A zero-length message therefore yields exactly one group: byte 0 is 0x01 and all other bytes are zero.
- R4: Bit c of the row-j word of a segment equals segment bit c·B+j, where segment bit k is bit (k mod 8) of segment byte k/8. With B=1 this is the segment bytes laid out little-endian, byte 0 in bits 7:0.
- R5: Each group emits 2·B words in the order primary row 0, partner row 0, primary row 1, partner row 1, and so on. The primary segment is group bytes 0 to 32·B−1 and the partner segment is group bytes 32·B to 64·B−1.
- R6: `out_last` is 1 only on the partner row B−1 word of the final group of a message, and 0 on every other word.
- R7: `in_ready` and `out_valid` are never high in the same cycle. No word of a group appears before the whole group has been received and padded.
- R8: While `out_valid` is 1 and `out_ready` is 0, the block holds `out_valid`, `out_data` and `out_last` unchanged into the next cycle.
- R9: In the first cycle after reset is released, `in_ready` is 1 and `out_valid` is 0.
- R10: An accepted beat with `in_empty`=1 and `in_last`=0 adds no byte and leaves the message in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts an input beat |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat ends the message |
| in_empty | input | 1 | Beat carries no byte |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 256 | Field-element word |
| out_last | output | 1 | Final word of the message |

## Verification
The message bytes are built from a position-dependent pattern, so every byte of a group holds a different value. With distinct bytes, an error in the transposition, in the choice between primary and partner segment, or in the row order shows up as a wrong word. Message lengths of zero, one, one byte short of a group, exactly one group and one byte over a group show apart whether padding fills the last group, adds a group, or places the 0x01 byte correctly. A no-byte beat placed inside a longer message shows that such a beat is dropped rather than stored as data. Random output backpressure, together with idle gaps on the input, tests that words are held steady and that input acceptance stops while a group is draining.

// File: rtl/bseg_pkg.sv
package bseg_pkg;

    localparam int WORD_W     = 256;
    localparam int SEG_UNIT_B = 32;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_PAD,
        ST_EMIT
    } seg_state_e;

    typedef struct packed {
        logic       en;
        logic [7:0] data;
    } wr_byte_t;

    // Bit position inside the buffered group of the bit that feeds
    // column col of row word row in segment seg.
    function automatic int src_bit(input int seg, input int col,
                                   input int row, input int rows);
        return seg * WORD_W * rows + col * rows + row;
    endfunction

endpackage

// File: rtl/bseg_ctrl.sv
module bseg_ctrl
    import bseg_pkg::*;
#(
    parameter int B = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [7:0]                   in_data,
    input  logic                         in_last,
    input  logic                         in_empty,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic                         out_last,
    output wr_byte_t                     wr,
    output logic [$clog2(64*B)-1:0]      wr_addr,
    output logic [$clog2(2*B)-1:0]       rd_idx
);
    localparam int PAIR_BYTES = 2 * SEG_UNIT_B * B;
    localparam int AW         = $clog2(PAIR_BYTES);
    localparam int WORDS      = 2 * B;
    localparam int IW         = $clog2(WORDS);

    seg_state_e    st_q;
    logic [AW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic          done_q;   // message end seen
    logic          one_q;    // pad byte 0x01 already written

    logic take, at_end, at_word_end;

    always_comb begin
        in_ready    = (st_q == ST_FILL);
        take        = in_valid && in_ready;
        at_end      = (cnt_q == AW'(PAIR_BYTES - 1));
        at_word_end = (idx_q == IW'(WORDS - 1));
        wr.en       = (take && !in_empty) || (st_q == ST_PAD);
        wr.data     = (st_q == ST_PAD) ? (one_q ? 8'h00 : 8'h01) : in_data;
        wr_addr     = cnt_q;
        rd_idx      = idx_q;
        out_valid   = (st_q == ST_EMIT);
        out_last    = out_valid && at_word_end && done_q && one_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_FILL;
            cnt_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
            one_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_FILL: begin
                    if (take) begin
                        if (in_last) begin
                            done_q <= 1'b1;
                            one_q  <= 1'b0;
                        end
                        if (in_empty) begin
                            if (in_last) st_q <= ST_PAD;
                        end else if (at_end) begin
                            cnt_q <= '0;
                            st_q  <= ST_EMIT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            if (in_last) st_q <= ST_PAD;
                        end
                    end
                end
                ST_PAD: begin
                    one_q <= 1'b1;
                    if (at_end) begin
                        cnt_q <= '0;
                        st_q  <= ST_EMIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        if (at_word_end) begin
                            idx_q <= '0;
                            if (done_q && one_q) begin
                                done_q <= 1'b0;
                                one_q  <= 1'b0;
                                st_q   <= ST_FILL;
                            end else if (done_q) begin
                                st_q <= ST_PAD;
                            end else begin
                                st_q <= ST_FILL;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: st_q <= ST_FILL;
            endcase
        end
    end

endmodule

// File: rtl/bseg_pair_buf.sv
module bseg_pair_buf
    import bseg_pkg::*;
#(
    parameter int B = 4
) (
    input  logic                         clk,
    input  wr_byte_t                     wr,
    input  logic [$clog2(64*B)-1:0]      wr_addr,
    input  logic [$clog2(2*B)-1:0]       rd_idx,
    output logic [WORD_W-1:0]            word
);
    localparam int PAIR_BYTES = 2 * SEG_UNIT_B * B;
    localparam int AW         = $clog2(PAIR_BYTES);

    logic [7:0] mem_q [PAIR_BYTES];

    always_ff @(posedge clk) begin
        if (wr.en) mem_q[wr_addr] <= wr.data;
    end

    int seg_sel, row_sel;

    always_comb begin
        seg_sel = int'(rd_idx[0]);
        row_sel = int'(rd_idx) >> 1;
    end

    for (genvar c = 0; c < WORD_W; c++) begin : g_col
        int k;
        always_comb begin
            k       = src_bit(seg_sel, c, row_sel, B);
            word[c] = mem_q[AW'(k >> 3)][k[2:0]];
        end
    end

endmodule

// File: rtl/msg_bitslice_segmenter.sv
module msg_bitslice_segmenter
    import bseg_pkg::*;
#(
    parameter int B = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [7:0]   in_data,
    input  logic         in_last,
    input  logic         in_empty,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [255:0] out_data,
    output logic         out_last
);
    localparam int AW = $clog2(2 * SEG_UNIT_B * B);
    localparam int IW = $clog2(2 * B);

    wr_byte_t      wr;
    logic [AW-1:0] wr_addr;
    logic [IW-1:0] rd_idx;

    bseg_ctrl #(.B(B)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_empty  (in_empty),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_last  (out_last),
        .wr        (wr),
        .wr_addr   (wr_addr),
        .rd_idx    (rd_idx)
    );

    bseg_pair_buf #(.B(B)) u_buf (
        .clk     (clk),
        .wr      (wr),
        .wr_addr (wr_addr),
        .rd_idx  (rd_idx),
        .word    (out_data)
    );

endmodule

// File: rtl/bseg_checker.sv
module bseg_checker #(
    parameter int B = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [255:0] out_data,
    input logic         out_last
);
    localparam int WORDS = 2 * B;
    int beat_q;

    always_ff @(posedge clk) begin
        if (rst) beat_q <= 0;
        else if (out_valid && out_ready) beat_q <= (beat_q == WORDS - 1) ? 0 : beat_q + 1;
    end

    p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    p_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> in_ready && !out_valid);

    p_last_position_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> beat_q == WORDS - 1);

    p_last_ends_burst_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last && out_ready |=> !out_valid && in_ready);

endmodule

bind msg_bitslice_segmenter bseg_checker #(.B(B)) u_bseg_checker (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tb_msg_bitslice_segmenter.sv
module tb_msg_bitslice_segmenter;
    localparam int NB   = 3;
    localparam int SEGB = 32 * NB;
    localparam int GRPB = 64 * NB;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid, in_last, in_empty, out_ready;
    logic [7:0]   in_data;
    logic         in_ready, out_valid, out_last;
    logic [255:0] out_data;

    always #2 clk = ~clk;

    msg_bitslice_segmenter #(.B(NB)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .in_empty(in_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [255:0] exp_w[$];
    bit           exp_l[$];
    string        exp_t[$];

    // Reference: pad, split into groups, transpose, interleave.
    function automatic void model(input byte unsigned m[$], input string tag);
        byte unsigned p[$];
        int ng;
        p = m;
        p.push_back(8'h01);
        while (p.size() % GRPB != 0) p.push_back(8'h00);
        ng = p.size() / GRPB;
        for (int g = 0; g < ng; g++)
            for (int j = 0; j < NB; j++)
                for (int s = 0; s < 2; s++) begin
                    logic [255:0] w;
                    for (int c = 0; c < 256; c++) begin
                        int k;
                        k = c * NB + j;
                        w[c] = p[g * GRPB + s * SEGB + k / 8][k % 8];
                    end
                    exp_w.push_back(w);
                    exp_l.push_back(g == ng - 1 && j == NB - 1 && s == 1);
                    exp_t.push_back(tag);
                end
    endfunction

    // Monitor: every clock, between edges.
    bit           hold_pend = 0;
    logic [255:0] hold_d;
    logic         hold_l;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (in_ready && out_valid) begin
                errors++;
                $display("FAIL R7: in_ready=%b out_valid=%b, expected not both high", in_ready, out_valid);
            end
            if (hold_pend) begin
                checks++;
                if (!out_valid || out_data !== hold_d || out_last !== hold_l) begin
                    errors++;
                    $display("FAIL R8: held word changed, got v=%b l=%b %h expected v=1 l=%b %h",
                             out_valid, out_last, out_data, hold_l, hold_d);
                end
            end
            if (out_valid && out_ready) begin
                checks++;
                if (exp_w.size() == 0) begin
                    errors++;
                    $display("FAIL R5: unexpected word %h, expected none", out_data);
                end else begin
                    if (out_data !== exp_w[0]) begin
                        errors++;
                        $display("FAIL R4/R5 (%s): got %h expected %h", exp_t[0], out_data, exp_w[0]);
                    end
                    checks++;
                    if (out_last !== exp_l[0]) begin
                        errors++;
                        $display("FAIL R6 (%s): out_last got %b expected %b", exp_t[0], out_last, exp_l[0]);
                    end
                    void'(exp_w.pop_front());
                    void'(exp_l.pop_front());
                    void'(exp_t.pop_front());
                end
            end
            hold_pend = out_valid && !out_ready;
            hold_d    = out_data;
            hold_l    = out_last;
        end
    end

    // Output backpressure pattern.
    always @(posedge clk) begin
        #1 out_ready <= ($urandom % 4) != 0;
    end

    task automatic beat(input logic [7:0] d, input logic l, input logic e);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        in_empty = e;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_empty = 1'b0;
    endtask

    task automatic send_msg(input int len, input int seed, input int gap_at, input string tag);
        byte unsigned m[$];
        for (int i = 0; i < len; i++) m.push_back(byte'((i * 37 + seed * 11 + (i >> 3)) & 8'hFF));
        model(m, tag);
        if (len == 0) begin
            beat(8'h5A, 1'b1, 1'b1);
        end else begin
            for (int i = 0; i < len; i++) begin
                if (i == gap_at) beat(8'hAA, 1'b0, 1'b1);
                beat(m[i], i == len - 1, 1'b0);
                if ((i + seed) % 7 == 0) begin
                    @(posedge clk);
                    #1;
                end
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_empty = 1'b0;
        in_data = 8'h00; out_ready = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (in_ready !== 1'b1 || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R9: in_ready=%b out_valid=%b expected 1 0", in_ready, out_valid);
        end
        @(posedge clk);
        #1;
        send_msg(0, 1, -1, "R3 empty message");
        send_msg(1, 2, -1, "R1 one byte");
        send_msg(GRPB - 1, 3, -1, "R1 one short of group");
        send_msg(GRPB, 4, -1, "R2 exact group");
        send_msg(GRPB + 1, 5, -1, "R2 group plus one");
        send_msg(300, 6, 50, "R10 no-byte beat inside");
        send_msg(2 * SEGB - 5, 7, 0, "R10 no-byte beat first");
        for (int t = 0; t < 4000 && exp_w.size() != 0; t++) @(posedge clk);
        repeat (4) @(posedge clk);
        checks++;
        if (exp_w.size() != 0) begin
            errors++;
            $display("FAIL R1: %0d words missing, expected 0", exp_w.size());
        end
        finish_run();
    end

endmodule